// File: doc/BRIEF.md
# Two-Section Ripple Counter with Coincident Master Clear

This block is a four-bit event counter built from two separately clocked sections. The low section is a single toggle stage advanced by count input A. The high section is a three-stage toggle chain advanced by count input B. When the link select is high, the high section takes its count from the low stage's 1-to-0 transition instead of from input B, so pulses on A count through all sixteen states. When the link select is low, the high section counts pulses on B on its own and wraps every eight. Counting happens on falling edges of the count inputs.

The count inputs are treated as asynchronous event lines. They are synchronised into the block clock domain, and the ripple from stage to stage is resolved inside one clock cycle. A master clear takes effect only while both of its inputs are high. It forces the output to zero in the same cycle and empties the stages. A build parameter can take the two clear inputs from chosen count bits instead of from the ports. This gives shorter count cycles with no extra logic: bits 0 and 3 give a count cycle of nine, and bit 2 on both inputs gives a count cycle of four. The terminal state then lasts one internal cycle and never shows at the output.

Top module: `split_ripple_counter`

## Requirements
- R1: Each falling edge on `cnt_a_i` toggles `count_o[0]`. The change is visible at most four block clock cycles after the edge.
- R2: With `link_i` low, each falling edge on `cnt_b_i` advances `count_o[3:1]` by one, wrapping from 7 to 0.
- R3: With `link_i` high, each 1-to-0 change of `count_o[0]` advances `count_o[3:1]`, so pulses on `cnt_a_i` step `count_o` through 0 to 15 and back to 0.
- R4: With `link_i` high, edges on `cnt_b_i` leave `count_o` unchanged.
- R5: While `mclr_x_i` and `mclr_y_i` are both high, `count_o` reads 0 in the same cycle and stays 0 through any count edges. After release, counting resumes from 0.
- R6: With only one of `mclr_x_i` and `mclr_y_i` high, the count is unaffected.
- R7: Rising edges on either count input do not change the count.
- R8: With feedback enabled on bits 0 and 3, pulses on `cnt_a_i` (link high) give the sequence 0,1,...,8,0. The value 9 never appears on `count_o`.
- R9: With feedback enabled on bit 2 for both clear inputs, pulses on `cnt_a_i` give the sequence 0,1,2,3,0.
- R10: While `rst_n` is low, `count_o` is 0.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_a_i | input | 1 | Count input of the low section (falling edge) |
| cnt_b_i | input | 1 | Count input of the high section (falling edge) |
| link_i | input | 1 | 1: the high section is driven by the low stage's output |
| mclr_x_i | input | 1 | Master clear input X; clears only together with Y |
| mclr_y_i | input | 1 | Master clear input Y; clears only together with X |
| count_o | output | 4 | Count value, bit 0 from the low section |

## Verification
The bench goes after these corner cases:

- **Carry from 7 to 8 and wrap from 15 to 0 in linked mode.** A chain that ripples on the wrong transition of the low stage would skip states or advance early.
- **Ignored edges on input B when linked.** A missing select would double-count.
- **Each clear input on its own.** An OR-combined clear would wipe the count.
- **Count edges while the clear is held.** The output must stay at zero.
- **Shortened count cycles.** A build that let the terminal state reach the output, or cleared one state late, would show 9 or 4 or a count cycle of the wrong length.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic {
    SRC_OWN  = 1'b0,
    SRC_LINK = 1'b1
  } hi_src_e;

  localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/cnt_reset_sync.sv
module cnt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/cnt_edge_fall.sv
module cnt_edge_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              cur;

  assign cur = sync_q[STAGES-1];

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= cur;
    end
  end

  assign fall_o = prev_q & ~cur;

  // one pulse per falling edge
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);  // R7
endmodule

// File: rtl/cnt_toggle_chain.sv
module cnt_toggle_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              clr_i,
  output logic [STAGES-1:0] q_o,
  output logic              carry_o
);
  logic [STAGES:0]   trig;
  logic [STAGES-1:0] q_q;
  logic [STAGES-1:0] q_d;

  assign trig[0] = tick_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    // a stage's falling output clocks the next stage
    assign trig[i+1] = trig[i] & q_q[i];
  end

  always_comb begin
    if (clr_i) q_d = '0;
    else       q_d = q_q ^ trig[STAGES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o     = q_q;
  assign carry_o = trig[STAGES];

  AST_FIRST_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !clr_i) |=> (q_q[0] != $past(q_q[0])));  // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_i) |=> $stable(q_q));  // R7
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q_q == '0));  // R5
endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter
  import cnt_pkg::*;
#(
  parameter int unsigned LO_STAGES  = 1,
  parameter int unsigned HI_STAGES  = 3,
  parameter int unsigned SYNC_DEPTH = MIN_SYNC,
  parameter bit          FB_EN      = 1'b0,
  parameter int unsigned FB_BIT_X   = 0,
  parameter int unsigned FB_BIT_Y   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cnt_a_i,
  input  logic                           cnt_b_i,
  input  logic                           link_i,
  input  logic                           mclr_x_i,
  input  logic                           mclr_y_i,
  output logic [LO_STAGES+HI_STAGES-1:0] count_o
);
  localparam int unsigned W = LO_STAGES + HI_STAGES;

  logic                 rst_q;
  logic                 fall_a;
  logic                 fall_b;
  logic                 lo_carry;
  logic                 hi_carry;
  logic                 hi_tick;
  logic                 clr_x;
  logic                 clr_y;
  logic                 clr_hit;
  hi_src_e              hi_src;
  logic [LO_STAGES-1:0] lo_q;
  logic [HI_STAGES-1:0] hi_q;
  logic [W-1:0]         cnt_q;

  cnt_reset_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  cnt_edge_fall #(.STAGES(SYNC_DEPTH)) u_fall_a (
    .clk(clk), .rst_n(rst_q), .async_i(cnt_a_i), .fall_o(fall_a)
  );

  cnt_edge_fall #(.STAGES(SYNC_DEPTH)) u_fall_b (
    .clk(clk), .rst_n(rst_q), .async_i(cnt_b_i), .fall_o(fall_b)
  );

  assign cnt_q = {hi_q, lo_q};

  if (FB_EN) begin : g_fb
    assign clr_x = cnt_q[FB_BIT_X];
    assign clr_y = cnt_q[FB_BIT_Y];
  end else begin : g_port
    assign clr_x = mclr_x_i;
    assign clr_y = mclr_y_i;
  end

  assign clr_hit = clr_x & clr_y;
  assign hi_src  = link_i ? SRC_LINK : SRC_OWN;

  always_comb begin
    case (hi_src)
      SRC_LINK: hi_tick = lo_carry;
      default:  hi_tick = fall_b;
    endcase
  end

  cnt_toggle_chain #(.STAGES(LO_STAGES)) u_lo (
    .clk(clk), .rst_n(rst_q), .tick_i(fall_a), .clr_i(clr_hit),
    .q_o(lo_q), .carry_o(lo_carry)
  );

  cnt_toggle_chain #(.STAGES(HI_STAGES)) u_hi (
    .clk(clk), .rst_n(rst_q), .tick_i(hi_tick), .clr_i(clr_hit),
    .q_o(hi_q), .carry_o(hi_carry)
  );

  assign count_o = (clr_hit || !rst_q) ? '0 : cnt_q;

  AST_CLEAR_NEXT_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    $past(clr_hit) |-> (cnt_q == '0));  // R5
  AST_LINK_IGNORES_B: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(link_i) && !$past(lo_carry) && !$past(clr_hit)) |-> $stable(hi_q));  // R4
  AST_OWN_CLOCK_B: assert property (@(posedge clk) disable iff (!rst_q)
    ($past(!link_i) && $past(fall_b) && !$past(clr_hit)) |-> (hi_q != $past(hi_q)));  // R2
  AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_q)
    (hi_carry && !clr_hit) |=> (hi_q == '0));  // R3
endmodule

// File: tb/split_ripple_counter_test.sv
`timescale 1ns/1ps
module split_ripple_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_a = 1'b0;
  logic cnt_b = 1'b0;
  logic link = 1'b1;
  logic mx = 1'b0;
  logic my = 1'b0;
  logic [3:0] cnt, cnt9, cnt4;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  logic       m_lo;
  logic [2:0] m_hi;
  int         m9, m4;

  always #2 clk = ~clk;

  split_ripple_counter uut (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .link_i(link), .mclr_x_i(mx), .mclr_y_i(my), .count_o(cnt)
  );

  split_ripple_counter #(.FB_EN(1'b1), .FB_BIT_X(0), .FB_BIT_Y(3)) uut9 (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(1'b0),
    .link_i(1'b1), .mclr_x_i(mx), .mclr_y_i(my), .count_o(cnt9)
  );

  split_ripple_counter #(.FB_EN(1'b1), .FB_BIT_X(2), .FB_BIT_Y(2)) uut4 (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(1'b0),
    .link_i(1'b1), .mclr_x_i(mx), .mclr_y_i(my), .count_o(cnt4)
  );

  function automatic logic [3:0] exp_main();
    return (mx && my) ? 4'd0 : {m_hi, m_lo};
  endfunction

  task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(tag, cnt, exp_main());
    chk("R8", cnt9, 4'(m9));
    chk("R9", cnt4, 4'(m4));
  endtask

  task automatic pulse_a();
    cnt_a = 1'b1;
    repeat (5) @(negedge clk);
    chk_all("R7");
    cnt_a = 1'b0;
    if (!(mx && my)) begin
      if (m_lo && link) m_hi = m_hi + 3'd1;
      m_lo = ~m_lo;
    end
    m9 = (m9 + 1) % 9;
    m4 = (m4 + 1) % 4;
    repeat (5) @(negedge clk);
  endtask

  task automatic pulse_b();
    cnt_b = 1'b1;
    repeat (5) @(negedge clk);
    chk_all("R7");
    cnt_b = 1'b0;
    if (!(mx && my) && !link) m_hi = m_hi + 3'd1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    m_lo = 1'b0; m_hi = 3'd0; m9 = 0; m4 = 0;
    repeat (4) @(negedge clk);
    chk("R10", cnt, 4'd0);
    chk("R10", cnt9, 4'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R10");

    // linked: full sixteen-state cycle, checking 7->8 and 15->0
    link = 1'b1;
    for (int i = 0; i < 17; i++) begin
      pulse_a();
      chk_all("R3");
    end
    // linked: B edges ignored
    for (int i = 0; i < 3; i++) begin
      pulse_b();
      chk_all("R4");
    end
    // own clock for high section, wrap at 8
    link = 1'b0;
    for (int i = 0; i < 9; i++) begin
      pulse_b();
      chk_all("R2");
    end
    pulse_a();
    chk_all("R1");
    // single clear inputs
    mx = 1'b1; repeat (3) @(negedge clk); chk_all("R6"); mx = 1'b0;
    my = 1'b1; repeat (3) @(negedge clk); chk_all("R6"); my = 1'b0;
    // coincident clear, immediate, held through edges
    mx = 1'b1; my = 1'b1;
    #1;
    chk("R5", cnt, 4'd0);
    m_lo = 1'b0; m_hi = 3'd0;
    @(negedge clk);
    pulse_a();
    chk_all("R5");
    pulse_b();
    chk_all("R5");
    mx = 1'b0; my = 1'b0;
    repeat (3) @(negedge clk);
    chk_all("R5");
    link = 1'b1;
    pulse_a();
    chk_all("R5");

    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 4) begin
        pulse_a(); chk_all("R1");
      end else if (r < 7) begin
        pulse_b(); chk_all(link ? "R4" : "R2");
      end else if (r < 8) begin
        link = ~link;
        repeat (2) @(negedge clk);
        chk_all("R7");
      end else if (r < 9) begin
        if ($urandom % 2) mx = 1'b1; else my = 1'b1;
        repeat (3) @(negedge clk);
        chk_all("R6");
        mx = 1'b0; my = 1'b0;
        @(negedge clk);
      end else begin
        mx = 1'b1; my = 1'b1;
        m_lo = 1'b0; m_hi = 3'd0;
        #1;
        chk("R5", cnt, 4'd0);
        @(negedge clk);
        mx = 1'b0; my = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R5");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule